// File: doc/BRIEF.md
# Carry and Condition Unit

This block holds the carry and status logic for a microcoded datapath. The adder's carry-out enters as a live "temporary carry". Whenever the current microinstruction belongs to a group-1 operation, that carry is copied into a one-bit "delayed carry" register, so later microinstructions can still test it. During a group-1 operation the architectural carry flag can also be written straight from the temporary carry.

A condition multiplexer picks one of eight sources for the microcode branch logic: the four architectural flags, the live temporary carry, the delayed carry, and the two constants. The selected condition is combinational from the current select code. This keeps the path from the adder carry to the selector short, and the adder carry passes through only the flag-load mux on its way to the carry register.

Top module: `carry_cond_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no enables asserted, `flags_q` and `dtc_q` are all zero.
- R2: On a rising edge with `grp1`=1, `dtc_q` takes the value of `tc_in`. With `grp1`=0, `dtc_q` holds its value.
- R3: On a rising edge with `grp1`=1 and `c_from_tc`=1, the carry flag (`flags_q[0]`) takes `tc_in`. This path has priority over `flag_we[0]`/`flag_in[0]`.
- R4: With `grp1`=0, `c_from_tc` has no effect. The carry flag loads `flag_in[0]` only when `flag_we[0]`=1 and otherwise holds.
- R5: The flag bits are: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow. For each bit i, a rising edge with `flag_we[i]`=1 loads `flag_in[i]`, subject to the R3 override on bit 0. A flag whose enable is low holds its value.
- R6: `cond_out` follows `cond_sel` combinationally: codes 0..3 give flag bits 0..3 (carry, zero, negative, overflow).
- R7: Code 4 gives the live `tc_in` in the same cycle. Code 5 gives `dtc_q`, which is the carry captured at an earlier group-1 edge.
- R8: Code 6 gives constant 1 and code 7 gives constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tc_in | input | 1 | Adder carry-out (temporary carry) |
| grp1 | input | 1 | Current microinstruction is a group-1 operation |
| c_from_tc | input | 1 | Load the carry flag from `tc_in` (group-1 only) |
| flag_in | input | 4 | New flag values: carry, zero, negative, overflow |
| flag_we | input | 4 | Per-flag write enables, same bit order |
| cond_sel | input | 3 | Condition select code |
| cond_out | output | 1 | Selected condition |
| flags_q | output | 4 | Architectural flag registers |
| dtc_q | output | 1 | Delayed temporary carry register |

## Verification
Directed sequences cover several cases. A group-1 capture is followed by non-group-1 cycles that toggle `tc_in` while the selector alternates between codes 4 and 5, which shows the live carry apart from the held copy. Conflicting requests drive `flag_in[0]` and `tc_in` to opposite values, with and without `grp1`, which shows the group-1 override and that `c_from_tc` is ignored outside group 1. Per-bit write patterns and a sweep of all eight select codes cover the flag bank and the selector. A long random stream then mixes every input, so that wrong bit positions or crossed enables are caught.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
   localparam int NUM_FLAGS = 4;
   localparam int FLAG_C    = 0;
   localparam int FLAG_Z    = 1;
   localparam int FLAG_N    = 2;
   localparam int FLAG_V    = 3;

   typedef enum logic [2:0] {
      SEL_C    = 3'd0,
      SEL_Z    = 3'd1,
      SEL_N    = 3'd2,
      SEL_V    = 3'd3,
      SEL_TC   = 3'd4,
      SEL_DTC  = 3'd5,
      SEL_ONE  = 3'd6,
      SEL_ZERO = 3'd7
   } cond_sel_e;
endpackage

// File: rtl/ccu_flag_bank.sv
module ccu_flag_bank
   import ccu_pkg::*;
#(
   parameter int N_FLAGS = NUM_FLAGS
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tc,
   input  logic               grp1,
   input  logic               c_from_tc,
   input  logic [N_FLAGS-1:0] flag_in,
   input  logic [N_FLAGS-1:0] flag_we,
   output logic [N_FLAGS-1:0] flags_q
);
   if (N_FLAGS <= FLAG_V) begin : g_bad_width
      $error("ccu_flag_bank: N_FLAGS must cover all four flags");
   end

   for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      logic bit_q;
      if (i == FLAG_C) begin : g_carry
         always_ff @(posedge clk) begin
            if (!rst_n)                 bit_q <= 1'b0;
            else if (grp1 && c_from_tc) bit_q <= tc;
            else if (flag_we[i])        bit_q <= flag_in[i];
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (flag_we[i]) bit_q <= flag_in[i];
         end
         // R5
         flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !flag_we[i] |=> $stable(flags_q[i]));
      end
      assign flags_q[i] = bit_q;
   end

   // R3
   c_from_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp1 && c_from_tc) |=> (flags_q[FLAG_C] == $past(tc)));

   // R4
   c_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp1 && !flag_we[FLAG_C]) |=> $stable(flags_q[FLAG_C]));
endmodule

// File: rtl/ccu_dtc_reg.sv
module ccu_dtc_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic tc,
   input  logic grp1,
   output logic dtc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    dtc_q <= 1'b0;
      else if (grp1) dtc_q <= tc;
   end

   // R2
   dtc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp1 |=> (dtc_q == $past(tc)));

   // R2
   dtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grp1 |=> $stable(dtc_q));
endmodule

// File: rtl/ccu_cond_mux.sv
module ccu_cond_mux #(
   parameter int SEL_W  = 3,
   parameter bit AND_OR = 1'b1,
   localparam int N_IN  = 1 << SEL_W
)(
   input  logic [N_IN-1:0]  cond_vec,
   input  logic [SEL_W-1:0] sel,
   output logic             cond
);
   if (SEL_W < 3 || SEL_W > 6) begin : g_bad_sel
      $error("ccu_cond_mux: SEL_W must lie in 3..6");
   end

   if (AND_OR) begin : g_and_or
      always_comb begin
         cond = 1'b0;
         for (int i = 0; i < N_IN; i++) begin
            cond = cond | ((sel == i[SEL_W-1:0]) & cond_vec[i]);
         end
      end
   end else begin : g_index
      assign cond = cond_vec[sel];
   end
endmodule

// File: rtl/carry_cond_unit.sv
module carry_cond_unit
   import ccu_pkg::*;
#(
   parameter int SEL_W      = 3,
   parameter bit MUX_AND_OR = 1'b1,
   localparam int N_IN      = 1 << SEL_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tc_in,
   input  logic                 grp1,
   input  logic                 c_from_tc,
   input  logic [NUM_FLAGS-1:0] flag_in,
   input  logic [NUM_FLAGS-1:0] flag_we,
   input  logic [SEL_W-1:0]     cond_sel,
   output logic                 cond_out,
   output logic [NUM_FLAGS-1:0] flags_q,
   output logic                 dtc_q
);
   logic [N_IN-1:0] cond_vec;

   ccu_flag_bank #(.N_FLAGS(NUM_FLAGS)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .tc        (tc_in),
      .grp1      (grp1),
      .c_from_tc (c_from_tc),
      .flag_in   (flag_in),
      .flag_we   (flag_we),
      .flags_q   (flags_q)
   );

   ccu_dtc_reg u_dtc (
      .clk   (clk),
      .rst_n (rst_n),
      .tc    (tc_in),
      .grp1  (grp1),
      .dtc_q (dtc_q)
   );

   always_comb begin
      cond_vec                 = '0;
      cond_vec[int'(SEL_C)]    = flags_q[FLAG_C];
      cond_vec[int'(SEL_Z)]    = flags_q[FLAG_Z];
      cond_vec[int'(SEL_N)]    = flags_q[FLAG_N];
      cond_vec[int'(SEL_V)]    = flags_q[FLAG_V];
      cond_vec[int'(SEL_TC)]   = tc_in;
      cond_vec[int'(SEL_DTC)]  = dtc_q;
      cond_vec[int'(SEL_ONE)]  = 1'b1;
      cond_vec[int'(SEL_ZERO)] = 1'b0;
   end

   ccu_cond_mux #(.SEL_W(SEL_W), .AND_OR(MUX_AND_OR)) u_mux (
      .cond_vec (cond_vec),
      .sel      (cond_sel),
      .cond     (cond_out)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (flags_q == '0 && dtc_q == 1'b0));

   // R7
   live_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == SEL_W'(SEL_TC)) |-> (cond_out == tc_in));

   // R8
   const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == SEL_W'(SEL_ONE)) |-> cond_out);

   // R8
   const_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == SEL_W'(SEL_ZERO)) |-> !cond_out);

   // R6
   carry_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == SEL_W'(SEL_C)) |-> (cond_out == flags_q[FLAG_C]));
endmodule

// File: tb/tb_carry_cond_unit.sv
`timescale 1ns/1ps
module tb_carry_cond_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tc_in = 1'b0;
   logic       grp1 = 1'b0;
   logic       c_from_tc = 1'b0;
   logic [3:0] flag_in = '0;
   logic [3:0] flag_we = '0;
   logic [2:0] cond_sel = 3'd7;
   logic       cond_out;
   logic [3:0] flags_q;
   logic       dtc_q;

   int checks = 0;
   int errors = 0;

   typedef struct {
      string      tag;
      logic       cond;
      logic [3:0] flags;
      logic       dtc;
   } exp_t;

   exp_t sb[$];

   logic [3:0] m_flags = '0;
   logic       m_dtc = 1'b0;

   always #2.5 clk = ~clk;

   carry_cond_unit dut (
      .clk(clk), .rst_n(rst_n), .tc_in(tc_in), .grp1(grp1),
      .c_from_tc(c_from_tc), .flag_in(flag_in), .flag_we(flag_we),
      .cond_sel(cond_sel), .cond_out(cond_out), .flags_q(flags_q),
      .dtc_q(dtc_q)
   );

   function automatic logic model_cond(input logic [2:0] s, input logic t);
      case (s)
         3'd0: return m_flags[0];
         3'd1: return m_flags[1];
         3'd2: return m_flags[2];
         3'd3: return m_flags[3];
         3'd4: return t;
         3'd5: return m_dtc;
         3'd6: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic step(input logic t, input logic g, input logic cft,
                       input logic [3:0] fin, input logic [3:0] fwe,
                       input logic [2:0] s, input string tag);
      exp_t e;
      @(negedge clk);
      tc_in = t; grp1 = g; c_from_tc = cft;
      flag_in = fin; flag_we = fwe; cond_sel = s;
      e.tag = tag; e.cond = model_cond(s, t);
      e.flags = m_flags; e.dtc = m_dtc;
      sb.push_back(e);
      for (int i = 1; i < 4; i++) if (fwe[i]) m_flags[i] = fin[i];
      if (g && cft)    m_flags[0] = t;
      else if (fwe[0]) m_flags[0] = fin[0];
      if (g) m_dtc = t;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() != 0) begin
            e = sb.pop_front();
            checks++;
            if (cond_out !== e.cond) begin
               errors++;
               $display("FAIL %s cond_out actual=%b expected=%b", e.tag, cond_out, e.cond);
            end
            checks++;
            if (flags_q !== e.flags) begin
               errors++;
               $display("FAIL %s flags_q actual=%b expected=%b", e.tag, flags_q, e.flags);
            end
            checks++;
            if (dtc_q !== e.dtc) begin
               errors++;
               $display("FAIL %s dtc_q actual=%b expected=%b", e.tag, dtc_q, e.dtc);
            end
         end
      end
   end

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R1: values held in reset
      #2;
      checks++;
      if (flags_q !== 4'b0 || dtc_q !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset actual=%b/%b expected=0000/0", flags_q, dtc_q);
      end
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 3'd7, "R1");
      step(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 3'd0, "R1");
      // R2 capture, then hold with live carry toggling (R7)
      step(1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 3'd5, "R2");
      step(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 3'd5, "R2");
      step(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 3'd4, "R7");
      step(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 3'd4, "R7");
      step(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 3'd5, "R7");
      step(1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 3'd5, "R2");
      step(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 3'd5, "R2");
      // R3 override: flag_in[0]=0 conflicts with tc=1
      step(1'b1, 1'b1, 1'b1, 4'h0, 4'h1, 3'd0, "R3");
      step(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 3'd0, "R3");
      step(1'b0, 1'b1, 1'b1, 4'h1, 4'h1, 3'd0, "R3");
      step(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 3'd0, "R3");
      // R4: c_from_tc without grp1 is ignored
      step(1'b1, 1'b0, 1'b1, 4'h0, 4'h0, 3'd0, "R4");
      step(1'b1, 1'b0, 1'b1, 4'h0, 4'h0, 3'd0, "R4");
      step(1'b1, 1'b0, 1'b1, 4'h1, 4'h1, 3'd0, "R4");
      step(1'b0, 1'b0, 1'b1, 4'h0, 4'h0, 3'd0, "R4");
      // R5: per-bit writes and holds
      step(1'b0, 1'b0, 1'b0, 4'hA, 4'hA, 3'd1, "R5");
      step(1'b0, 1'b0, 1'b0, 4'h5, 4'h4, 3'd3, "R5");
      step(1'b0, 1'b0, 1'b0, 4'hF, 4'h0, 3'd2, "R5");
      step(1'b0, 1'b0, 1'b0, 4'h0, 4'hF, 3'd1, "R5");
      step(1'b0, 1'b0, 1'b0, 4'h2, 4'h2, 3'd0, "R5");
      // R6 / R8: sweep all codes over a known state
      step(1'b1, 1'b1, 1'b0, 4'h9, 4'hF, 3'd0, "R6");
      for (int s = 0; s < 8; s++) begin
         step(s[0], 1'b0, 1'b0, 4'h0, 4'h0, 3'(s), (s >= 6) ? "R8" : "R6");
      end
      for (int s = 0; s < 8; s++) begin
         step(~s[0], 1'b0, 1'b0, 4'h0, 4'h0, 3'(s), (s >= 6) ? "R8" : "R6");
      end
      // random mix
      for (int k = 0; k < 400; k++) begin
         logic [12:0] r;
         r = 13'($urandom);
         step(r[0], r[1], r[2], r[6:3], r[10:7], {r[12:11], r[5]}, "R6");
      end
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule